// File: doc/BRIEF.md
# Local Interrupt Timer

This block is the per-processor countdown timer of a local interrupt controller. Software sets up a vector entry (an 8-bit vector, a mask flag and a periodic flag), picks a power-of-two clock prescale through a divide register and then writes an initial count. The write starts a new count. From that clock edge the block counts prescaled ticks. When the programmed period has elapsed it raises a one-cycle interrupt request that carries the vector.

In periodic mode a period lasts initial count plus one ticks. The request fires on every whole multiple of that period, measured from the load, so expiries never drift. In one-shot mode the request fires once, when the tick count reaches initial count plus one. After that the block stays quiet until the next load. Software can read the remaining count back at any time through the same register port. Writes are accepted on any cycle. Reads are combinational.

Top module: `lt_timer`

## Requirements
- R1: After reset the vector entry reads 0x0001_0000 (mask bit 16 set, periodic bit 17 clear, vector bits 7:0 zero). The divide, initial count and current count registers read zero and the request is low. Until the divide register is first written the prescale is divide-by-1, with one tick per clock.
- R2: Register addresses: 0 is the vector entry, 1 is divide, 2 is initial count and 3 is current count (read only). The divide value v = {bit3, bit1, bit0} selects a tick every 2^((v+1) mod 8) clocks, so 3'b111 means divide-by-1. Bit 2 is ignored and reads back as zero.
- R3: A write to initial count or to divide restarts the count, and the write edge becomes tick zero. Elapsed ticks equal the clocks since that edge, shifted right by the prescale shift.
- R4: In periodic mode with a nonzero initial count N, the request is high for exactly the first clock of each tick at which the elapsed tick count is a positive multiple of N+1.
- R5: In periodic mode with an initial count of zero the request never rises and the current count reads zero.
- R6: In one-shot mode with a nonzero initial count N, the request is high only in the first clock of the tick at which the elapsed count reaches N+1. With an initial count of zero it never rises.
- R7: In periodic mode the current count reads N minus (elapsed ticks mod (N+1)). In one-shot mode it reads N minus elapsed ticks, and zero once the elapsed count exceeds N.
- R8: While the mask bit is set the request stays low, but counting goes on. After unmasking, the next periodic expiry keeps to the original grid.
- R9: Whenever the request is high, the vector output equals vector entry bits 7:0.
- R10: The request never stays high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | CNT_W | Combinational read data |
| irq | output | 1 | One-cycle expiry request |
| irq_vector | output | VEC_W | Vector carried with the request |

## Verification
Some properties hold on every cycle, and the embedded assertions check those. A set mask, or a zero period in periodic mode, keeps the request low. The request never lasts two cycles. The phase never passes the initial count, and the remaining count stays within the initial count. The prescaler returns to zero after each tick. The exact expiry cycles are a different matter. So are the divide decoding, restart on load, the one-shot stop and the original grid kept through a masked stretch. Only the bench can show these, because its timestamp-based model predicts the request and the remaining count on every clock.

// File: rtl/lt_pkg.sv
// Shared constants and helpers for the local interrupt timer.
package lt_pkg;
    localparam int SHIFT_W  = 3;
    localparam int MASK_BIT = 16;
    localparam int PER_BIT  = 17;

    typedef enum logic [1:0] {
        ADDR_ENTRY = 2'd0,
        ADDR_DIV   = 2'd1,
        ADDR_INIT  = 2'd2,
        ADDR_COUNT = 2'd3
    } lt_addr_e;

    // Map divide bits {3,1,0} to a shift: (v+1) mod 8.
    function automatic logic [SHIFT_W-1:0] shift_from_div(input logic [3:0] d);
        logic [SHIFT_W-1:0] v;
        v = {d[3], d[1], d[0]};
        return v + 3'd1;
    endfunction
endpackage

// File: rtl/lt_prescaler.sv
// Power-of-two prescaler. It emits a tick on the last clock of every 2^shift
// clocks. Assumes shift only changes together with restart.
module lt_prescaler #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    // Terminal value of the prescale counter for the current shift.
    always_comb limit = (PRE_W'(1) << shift) - PRE_W'(1);

    assign tick = (pre_q == limit);

    // Advance the prescale counter, wrapping at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) pre_q <= '0;
        else if (tick)         pre_q <= '0;
        else                   pre_q <= pre_q + PRE_W'(1);
    end

    a_r2_tick_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_q == '0));
endmodule

// File: rtl/lt_period.sv
// Phase counter over one period of init+1 ticks. Produces a registered fire
// flag at each expiry. Assumes the mode stays stable while counting.
module lt_period #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic             periodic,
    input  logic [CNT_W-1:0] init,
    output logic [CNT_W-1:0] phase,
    output logic             expired,
    output logic             fire
);
    // Step the phase on each tick; wrap in periodic mode, stop in one-shot.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase   <= '0;
            expired <= 1'b0;
            fire    <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (tick && !expired) begin
                if (phase == init) begin
                    fire <= (init != '0);
                    if (periodic) phase <= '0;
                    else          expired <= 1'b1;
                end else begin
                    phase <= phase + CNT_W'(1);
                end
            end
        end
    end

    a_r7_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= init);
endmodule

// File: rtl/lt_timer.sv
// Local interrupt timer top: register port, prescaler and period counter.
// Assumes CNT_W >= 18 so the vector entry fits in one word.
module lt_timer
    import lt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq,
    output logic [VEC_W-1:0] irq_vector
);
    logic [VEC_W-1:0]   vec_q;
    logic               mask_q;
    logic               per_q;
    logic [3:0]         div_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [CNT_W-1:0]   init_q;
    logic               restart;
    logic               tick;
    logic [CNT_W-1:0]   phase;
    logic               expired;
    logic               fire;
    logic [CNT_W-1:0]   cur_count;

    assign restart = wr_en && (wr_addr == ADDR_INIT || wr_addr == ADDR_DIV);

    // Register file writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q   <= '0;
            mask_q  <= 1'b1;
            per_q   <= 1'b0;
            div_q   <= '0;
            shift_q <= '0;
            init_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_ENTRY: begin
                    vec_q  <= wr_data[VEC_W-1:0];
                    mask_q <= wr_data[MASK_BIT];
                    per_q  <= wr_data[PER_BIT];
                end
                ADDR_DIV: begin
                    div_q   <= {wr_data[3], 1'b0, wr_data[1:0]};
                    shift_q <= shift_from_div(wr_data[3:0]);
                end
                ADDR_INIT: init_q <= wr_data;
                default: ;
            endcase
        end
    end

    lt_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart), .shift(shift_q), .tick(tick)
    );

    lt_period #(.CNT_W(CNT_W)) u_per (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
        .periodic(per_q), .init(init_q), .phase(phase),
        .expired(expired), .fire(fire)
    );

    // Remaining count: zero once a one-shot run has expired.
    always_comb cur_count = expired ? '0 : (init_q - phase);

    // Combinational read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_ENTRY: begin
                rd_data[VEC_W-1:0] = vec_q;
                rd_data[MASK_BIT]  = mask_q;
                rd_data[PER_BIT]   = per_q;
            end
            ADDR_DIV:   rd_data[3:0] = div_q;
            ADDR_INIT:  rd_data = init_q;
            default:    rd_data = cur_count;
        endcase
    end

    assign irq        = fire && !mask_q;
    assign irq_vector = vec_q;

    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !irq);
    a_r5_zero_period_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q && init_q == '0) |-> !irq);
    a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cur_count <= init_q);
endmodule

// File: tb/lt_timer_test.sv
module lt_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd3;
    logic [31:0] rd_data;
    logic        irq;
    logic [7:0]  irq_vector;

    int    checks = 0;
    int    failures = 0;
    bit    live = 1'b0;
    string cur_req = "R1";

    // Timestamp-style reference state.
    bit      m_mask, m_per;
    int      m_vec, m_shift;
    longint  m_init, nsl;

    lt_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .irq_vector(irq_vector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: track writes and clocks since the last load.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 1; m_per = 0; m_vec = 0; m_shift = 0; m_init = 0; nsl = 0;
        end else if (wr_en && (wr_addr == 2'd2 || wr_addr == 2'd1)) begin
            if (wr_addr == 2'd2) m_init = longint'(wr_data);
            else m_shift = ({wr_data[3], wr_data[1], wr_data[0]} + 1) % 8;
            nsl = 0;
        end else begin
            if (wr_en && wr_addr == 2'd0) begin
                m_vec = int'(wr_data[7:0]); m_mask = wr_data[16]; m_per = wr_data[17];
            end
            nsl = nsl + 1;
        end
    end

    function automatic bit exp_irq();
        longint e;
        if (m_mask || m_init == 0) return 0;
        if (nsl % (longint'(1) << m_shift) != 0) return 0;
        e = nsl >> m_shift;
        if (e == 0) return 0;
        if (m_per) return (e % (m_init + 1)) == 0;
        return e == m_init + 1;
    endfunction

    function automatic longint exp_count();
        longint e;
        e = nsl >> m_shift;
        if (m_per) return (m_init == 0) ? 0 : m_init - (e % (m_init + 1));
        return (e > m_init) ? 0 : m_init - e;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare request, vector and remaining count on every clock.
    always @(negedge clk) begin
        if (live) begin
            check(cur_req, "irq", longint'(irq), longint'(exp_irq()));
            if (exp_irq()) check("R9", "vector", longint'(irq_vector), longint'(m_vec));
            if (rd_addr == 2'd3) check("R7", "count", longint'(rd_data), exp_count());
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); #2;
        rd_addr = a; #1;
        check(req, "read", longint'(rd_data), longint'(exp));
        rd_addr = 2'd3;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Quiet the count, then set the entry, optional divide and the load.
    task automatic setup(input logic [31:0] entry, input bit do_div,
                         input logic [3:0] div, input logic [31:0] init);
        wr(2'd2, 32'd0);
        wr(2'd0, entry);
        if (do_div) wr(2'd1, {28'd0, div});
        wr(2'd2, init);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        live = 1;
        // R1 reset state
        rd_check(2'd0, 32'h0001_0000, "R1");
        rd_check(2'd1, 32'h0, "R1");
        rd_check(2'd2, 32'h0, "R1");
        rd_check(2'd3, 32'h0, "R1");
        idle(4);
        // R1 divide-by-1 before any divide write; R4 periodic grid
        cur_req = "R4";
        setup(32'h0002_0041, 0, 4'h0, 32'd3);
        idle(20);
        // R5 zero period in periodic mode
        cur_req = "R5";
        wr(2'd2, 32'd0);
        idle(12);
        // R2 divide decoding: v=1 -> divide 4
        cur_req = "R2";
        setup(32'h0002_0055, 1, 4'h1, 32'd2);
        rd_check(2'd1, 32'h1, "R2");
        idle(40);
        // R2 bit 2 ignored, all ones -> divide 1
        wr(2'd1, 32'hF);
        rd_check(2'd1, 32'hB, "R2");
        idle(12);
        // R2 v=6 -> divide 128, period 2 ticks
        wr(2'd1, 32'hA);
        wr(2'd2, 32'd1);
        idle(530);
        // R6 one-shot, divide 2
        cur_req = "R6";
        setup(32'h0000_0022, 1, 4'h0, 32'd3);
        idle(30);
        rd_check(2'd3, 32'h0, "R6");
        wr(2'd2, 32'd0);
        idle(10);
        // R8 masked periodic keeps counting, then unmask on same grid
        cur_req = "R8";
        setup(32'h0003_0077, 1, 4'hB, 32'd2);
        idle(10);
        wr(2'd0, 32'h0002_0077);
        idle(12);
        // R3 reload mid-count restarts
        cur_req = "R3";
        setup(32'h0002_0013, 1, 4'hB, 32'd5);
        idle(4);
        wr(2'd2, 32'd5);
        idle(15);
        // R7 large count readback
        cur_req = "R7";
        setup(32'h0001_0000, 1, 4'hB, 32'hFFFF_FFF0);
        idle(3);
        rd_check(2'd2, 32'hFFFF_FFF0, "R7");
        idle(3);
        live = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule